// File: doc/BRIEF.md
# SD Card SPI-Mode Command Sequencer

This block issues a single SD-card command in SPI mode and brings back the card's first response byte. An optional four-byte trailer, such as the operating-conditions word, can be collected after it. It works above a byte-wide SPI master. For each byte it asks the master for one exchange, then waits for the byte the card returned.

Around every command it enforces the timing habits that slower cards depend on. Before the frame it sends filler bytes until the card reports ready, which means the card returns all ones. After the frame it polls for the response within a fixed bound. It finishes with one extra filler byte, which gives the card the eight clocks it needs to settle before the next command.

The host supplies the command index, the argument and a CRC byte. The CRC is sent exactly as given. The host then pulses start and waits for a one-cycle completion pulse. A timeout flag reports a card that never became ready or never answered.

Top module: `sdCmdSeq`

## Requirements
- R1: The frame is six bytes, sent in this order: `0x40 | cmdIdx`, then the four argument bytes most significant first, then `cmdCrc` unchanged.
- R2: Before the frame, each exchange sends 0xFF. The frame begins on the exchange right after the first exchange whose reply is 0xFF, so the preamble takes one exchange more than the number of non-0xFF replies.
- R3: If 255 preamble exchanges pass with no 0xFF reply, the transaction ends with `timeout` = 1 and `r1Out` = 0xFF. No frame byte is sent and no extra byte follows.
- R4: After the frame, 0xFF is sent repeatedly. The first reply with bit 7 = 0 is stored in `r1Out` unchanged, including the idle flag in bit 0 and the illegal-command flag in bit 2.
- R5: If 8 polls bring no reply with bit 7 = 0, `timeout` = 1, `r1Out` = 0xFF and no trailer is read.
- R6: When `wantTrailer` = 1 and a response was found, four more 0xFF exchanges follow, and their replies are packed first-received-in-bits-31:24 into `trailerOut`. Otherwise `trailerOut` reads 0 after the transaction.
- R7: Exactly one extra 0xFF exchange follows the response, the trailer or a poll timeout. No exchange is requested after `done`.
- R8: `done` is high for exactly one cycle at the end of a transaction, and `busy` is low in that cycle. `busy` is high from the accepted start until then.
- R9: A `startI` pulse while `busy` is high has no effect. The frame sent and the number of exchanges are those of the running command.
- R10: After reset, `busy`, `done`, `timeout` and `xferGo` are 0, `r1Out` is 0xFF and `trailerOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startI | input | 1 | Start strobe, taken only when idle |
| cmdIdx | input | 6 | Command index |
| cmdArg | input | 32 | Command argument |
| cmdCrc | input | 8 | CRC byte, sent unchanged |
| wantTrailer | input | 1 | Read four trailer bytes after the response |
| xferReady | input | 1 | SPI master can accept a byte |
| xferGo | output | 1 | Request one byte exchange |
| xferTx | output | 8 | Byte to transmit with `xferGo` |
| rxValid | input | 1 | Reply byte of the pending exchange is valid |
| rxByte | input | 8 | Reply byte from the card |
| r1Out | output | 8 | Response byte, or 0xFF on timeout |
| trailerOut | output | 32 | Trailer word |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Ready-wait or response-poll bound exceeded |

## Verification
The card model is given a number of busy replies before it reports ready, and a number of filler replies before its response. The vectors vary both. A response on the first poll, on the eighth poll and never separates the poll-bound logic from an off-by-one error. Commands with and without a trailer, run back to back, show that the trailer is read only when asked for and that it is cleared between commands. Separate runs cover a card that never becomes ready, a start pulse while busy, and the exact number of exchanges before and after the frame, which is where a missing preamble or a missing extra byte would show.

// File: rtl/sdCmdPkg.sv
package sdCmdPkg;
  localparam int FRAME_BYTES = 6;
  localparam int FRAME_W = FRAME_BYTES * 8;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [1:0] START_BITS = 2'b01;

  typedef struct packed {
    logic load;
    logic sendFrame;
    logic shiftFrame;
    logic capR1;
    logic setTimeout;
    logic shiftTrail;
    logic cntClr;
    logic cntInc;
  } dpCtrl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_FRAME, ST_POLL, ST_TRAIL, ST_EXTRA
  } seqState_t;
endpackage

// File: rtl/sdCmdData.sv
module sdCmdData
  import sdCmdPkg::*;
#(
  parameter int TRAIL_BYTES = 4,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpCtrl_t                  ctl,
  input  logic [5:0]               cmdIdx,
  input  logic [31:0]              cmdArg,
  input  logic [7:0]               cmdCrc,
  input  logic                     wantTrailer,
  input  logic [7:0]               rxByte,
  output logic [7:0]               txByte,
  output logic [CNT_W-1:0]         cnt,
  output logic                     trailerWanted,
  output logic [7:0]               r1Out,
  output logic [TRAIL_BYTES*8-1:0] trailerOut,
  output logic                     timeout
);
  localparam int TRAIL_W = TRAIL_BYTES * 8;

  logic [FRAME_W-1:0] frameReg;

  // Head of the frame shifter, or filler outside the frame phase.
  assign txByte = ctl.sendFrame ? frameReg[FRAME_W-1 -: 8] : FILL_BYTE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameReg      <= '1;
      trailerWanted <= 1'b0;
      r1Out         <= FILL_BYTE;
      trailerOut    <= '0;
      timeout       <= 1'b0;
    end else begin
      if (ctl.load) begin
        frameReg      <= {START_BITS, cmdIdx, cmdArg, cmdCrc};
        trailerWanted <= wantTrailer;
        r1Out         <= FILL_BYTE;
        trailerOut    <= '0;
        timeout       <= 1'b0;
      end
      if (ctl.shiftFrame) frameReg <= {frameReg[FRAME_W-9:0], FILL_BYTE};
      if (ctl.capR1)      r1Out <= rxByte;
      if (ctl.setTimeout) timeout <= 1'b1;
      if (ctl.shiftTrail) trailerOut <= {trailerOut[TRAIL_W-9:0], rxByte};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           cnt <= '0;
    else if (ctl.cntClr) cnt <= '0;
    else if (ctl.cntInc) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdCmdCtrl.sv
module sdCmdCtrl
  import sdCmdPkg::*;
#(
  parameter int PRE_MAX = 255,
  parameter int POLL_MAX = 8,
  parameter int TRAIL_BYTES = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startI,
  input  logic             xferReady,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic [CNT_W-1:0] cnt,
  input  logic             trailerWanted,
  output dpCtrl_t          ctl,
  output logic             xferGo,
  output logic             busy,
  output logic             done
);
  localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_MAX - 1);
  localparam logic [CNT_W-1:0] POLL_LAST  = CNT_W'(POLL_MAX - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0] TRAIL_LAST = CNT_W'(TRAIL_BYTES - 1);

  seqState_t state, nxt;
  logic inFlight, replyHere, finish, byteState;

  assign busy      = (state != ST_IDLE);
  assign byteState = busy;
  assign xferGo    = byteState && !inFlight && xferReady;
  assign replyHere = byteState && inFlight && rxValid;

  always_comb begin
    ctl = '0;
    nxt = state;
    finish = 1'b0;
    ctl.sendFrame = (state == ST_FRAME);
    unique case (state)
      ST_IDLE: if (startI) begin
        ctl.load = 1'b1;
        ctl.cntClr = 1'b1;
        nxt = ST_PRE;
      end
      ST_PRE: if (replyHere) begin
        if (rxByte == FILL_BYTE) begin
          ctl.cntClr = 1'b1;
          nxt = ST_FRAME;
        end else if (cnt == PRE_LAST) begin
          ctl.setTimeout = 1'b1;
          finish = 1'b1;
          nxt = ST_IDLE;
        end else ctl.cntInc = 1'b1;
      end
      ST_FRAME: if (replyHere) begin
        ctl.shiftFrame = 1'b1;
        if (cnt == FRAME_LAST) begin
          ctl.cntClr = 1'b1;
          nxt = ST_POLL;
        end else ctl.cntInc = 1'b1;
      end
      ST_POLL: if (replyHere) begin
        if (!rxByte[7]) begin
          ctl.capR1 = 1'b1;
          ctl.cntClr = 1'b1;
          nxt = trailerWanted ? ST_TRAIL : ST_EXTRA;
        end else if (cnt == POLL_LAST) begin
          ctl.setTimeout = 1'b1;
          nxt = ST_EXTRA;
        end else ctl.cntInc = 1'b1;
      end
      ST_TRAIL: if (replyHere) begin
        ctl.shiftTrail = 1'b1;
        if (cnt == TRAIL_LAST) nxt = ST_EXTRA;
        else ctl.cntInc = 1'b1;
      end
      ST_EXTRA: if (replyHere) begin
        finish = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      inFlight <= 1'b0;
      done     <= 1'b0;
    end else begin
      state <= nxt;
      done  <= finish;
      if (xferGo)         inFlight <= 1'b1;
      else if (replyHere) inFlight <= 1'b0;
    end
  end
endmodule

// File: rtl/sdCmdSeq.sv
module sdCmdSeq
  import sdCmdPkg::*;
#(
  parameter int PRE_MAX = 255,
  parameter int POLL_MAX = 8,
  parameter int TRAIL_BYTES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startI,
  input  logic [5:0]  cmdIdx,
  input  logic [31:0] cmdArg,
  input  logic [7:0]  cmdCrc,
  input  logic        wantTrailer,
  input  logic        xferReady,
  output logic        xferGo,
  output logic [7:0]  xferTx,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  output logic [7:0]  r1Out,
  output logic [31:0] trailerOut,
  output logic        busy,
  output logic        done,
  output logic        timeout
);
  localparam int CNT_MAX = (PRE_MAX > POLL_MAX) ? PRE_MAX : POLL_MAX;
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  dpCtrl_t ctl;
  logic [CNT_W-1:0] cnt;
  logic trailerWanted;

  sdCmdCtrl #(.PRE_MAX(PRE_MAX), .POLL_MAX(POLL_MAX), .TRAIL_BYTES(TRAIL_BYTES), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .startI(startI), .xferReady(xferReady), .rxValid(rxValid),
    .rxByte(rxByte), .cnt(cnt), .trailerWanted(trailerWanted), .ctl(ctl),
    .xferGo(xferGo), .busy(busy), .done(done));

  sdCmdData #(.TRAIL_BYTES(TRAIL_BYTES), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdIdx(cmdIdx), .cmdArg(cmdArg), .cmdCrc(cmdCrc),
    .wantTrailer(wantTrailer), .rxByte(rxByte), .txByte(xferTx), .cnt(cnt),
    .trailerWanted(trailerWanted), .r1Out(r1Out), .trailerOut(trailerOut), .timeout(timeout));
endmodule

// File: rtl/sdCmdSeqChk.sv
module sdCmdSeqChk (
  input logic        clk,
  input logic        rstN,
  input logic        startI,
  input logic        xferReady,
  input logic        xferGo,
  input logic [7:0]  r1Out,
  input logic [31:0] trailerOut,
  input logic        busy,
  input logic        done,
  input logic        timeout
);
  // R8: completion pulse lasts a single cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R8: engine is idle when it signals completion
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy);
  // R7: exchanges are requested only inside a transaction and only when the master is ready
  a_r7_go_in_txn: assert property (@(posedge clk) disable iff (!rstN) xferGo |-> (busy && xferReady));
  // R3/R5: a timed-out command reports 0xFF and no trailer
  a_r5_timeout_r1: assert property (@(posedge clk) disable iff (!rstN) (done && timeout) |-> (r1Out == 8'hFF));
  a_r6_timeout_notrail: assert property (@(posedge clk) disable iff (!rstN) (done && timeout) |-> (trailerOut == 32'h0));
  // R4: a found response always has bit 7 clear
  a_r4_r1_msb: assert property (@(posedge clk) disable iff (!rstN) (done && !timeout) |-> !r1Out[7]);
  // R9: a start while busy does not restart; results stay put during a transaction
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rstN) (busy && startI) |=> busy || done);
endmodule

bind sdCmdSeq sdCmdSeqChk uChk (
  .clk(clk), .rstN(rstN), .startI(startI), .xferReady(xferReady), .xferGo(xferGo),
  .r1Out(r1Out), .trailerOut(trailerOut), .busy(busy), .done(done), .timeout(timeout));

// File: tb/tb_sdCmdSeq.sv
`timescale 1ns/1ps
module tb_sdCmdSeq;
  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] arg;
    logic [7:0]  crc;
    logic        trail;
    logic [15:0] busyN;
    logic [7:0]  pollN;
    logic [7:0]  r1;
    logic [31:0] word;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{6'd0,  32'h0000_0000, 8'h95, 1'b0, 16'd0, 8'd0, 8'h01, 32'h0},
    '{6'd8,  32'h0000_01AA, 8'h87, 1'b1, 16'd2, 8'd0, 8'h01, 32'h0000_01AA},
    '{6'd58, 32'h0000_0000, 8'hFD, 1'b1, 16'd0, 8'd3, 8'h05, 32'h00FF_8000},
    '{6'd55, 32'h0000_0000, 8'h65, 1'b0, 16'd1, 8'd7, 8'h00, 32'h0},
    '{6'd41, 32'h4000_0000, 8'hE5, 1'b1, 16'd0, 8'd20, 8'h00, 32'h1234_5678},
    '{6'd1,  32'h0000_0000, 8'hF9, 1'b0, 16'd5, 8'd2, 8'h05, 32'h0},
    '{6'd13, 32'h0000_0000, 8'h0D, 1'b0, 16'd0, 8'd1, 8'h7F, 32'h0}
  };

  logic clk = 0, rstN = 0, startI = 0, wantTrailer = 0;
  logic [5:0] cmdIdx = 0; logic [31:0] cmdArg = 0; logic [7:0] cmdCrc = 0;
  logic xferReady, xferGo, rxValid, busy, done, timeout;
  logic [7:0] xferTx, rxByte, r1Out; logic [31:0] trailerOut;
  int checks = 0, failures = 0, cycles = 0;

  always #4 clk = ~clk;

  sdCmdSeq dut (.clk(clk), .rstN(rstN), .startI(startI), .cmdIdx(cmdIdx), .cmdArg(cmdArg),
    .cmdCrc(cmdCrc), .wantTrailer(wantTrailer), .xferReady(xferReady), .xferGo(xferGo),
    .xferTx(xferTx), .rxValid(rxValid), .rxByte(rxByte), .r1Out(r1Out), .trailerOut(trailerOut),
    .busy(busy), .done(done), .timeout(timeout));

  // Card configuration (written by the stimulus only)
  int cfgBusy = 0, cfgPoll = 0; logic cfgTrail = 0; logic [7:0] cfgR1 = 8'h01; logic [31:0] cfgWord = 0;
  // Card/master model state (written by the model only)
  int phase, preLeft, pollLeft, trlIdx, preCount, afterFrame, frmN, totalX, lat;
  logic [7:0] frm [6]; logic [7:0] pend, rep;

  always @(posedge clk) begin
    if (!rstN) begin
      xferReady <= 1'b1; rxValid <= 1'b0; rxByte <= 8'h00; lat = 0;
      phase = 0; frmN = 0; totalX = 0; preCount = 0; afterFrame = 0;
    end else begin
      if (startI && !busy) begin
        phase = 0; preLeft = cfgBusy; pollLeft = cfgPoll; trlIdx = 0;
        preCount = 0; afterFrame = 0; frmN = 0;
      end
      rxValid <= 1'b0;
      if (lat > 0) begin
        lat = lat - 1;
        if (lat == 0) begin rxValid <= 1'b1; rxByte <= pend; xferReady <= 1'b1; end
      end else if (xferGo && xferReady) begin
        totalX = totalX + 1;
        rep = 8'hFF;
        case (phase)
          0: if (xferTx[7:6] == 2'b01) begin
               frm[0] = xferTx; frmN = 1; phase = 1;
             end else begin
               preCount = preCount + 1;
               if (preLeft > 0) begin preLeft = preLeft - 1; rep = 8'h00; end
             end
          1: begin
               if (frmN < 6) frm[frmN] = xferTx;
               frmN = frmN + 1;
               if (frmN == 6) phase = 2;
             end
          2: begin
               afterFrame = afterFrame + 1;
               if (pollLeft > 0) pollLeft = pollLeft - 1;
               else begin rep = cfgR1; phase = 3; end
             end
          default: begin
               afterFrame = afterFrame + 1;
               if (cfgTrail && trlIdx < 4) begin rep = cfgWord[31 - 8*trlIdx -: 8]; trlIdx = trlIdx + 1; end
             end
        endcase
        pend = rep; xferReady <= 1'b0; lat = 2;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitDone(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    cfgBusy = int'(v.busyN); cfgPoll = int'(v.pollN); cfgTrail = v.trail; cfgR1 = v.r1; cfgWord = v.word;
    cmdIdx = v.idx; cmdArg = v.arg; cmdCrc = v.crc; wantTrailer = v.trail;
    startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
  endtask

  task automatic checkTxn(input vec_t v, input bit seen);
    bit found; int expAfter, xAtDone;
    logic [47:0] expFrame;
    found = (v.pollN < 8);
    expAfter = found ? int'(v.pollN) + 1 + (v.trail ? 4 : 0) + 1 : 9;
    expFrame = {2'b01, v.idx, v.arg, v.crc};
    chk("R8 done seen", 32'(seen), 1);
    chk("R8 busy low at done", 32'(busy), 0);
    chk("R4 r1 value", 32'(r1Out), found ? 32'(v.r1) : 32'hFF);
    chk("R5 timeout flag", 32'(timeout), found ? 0 : 1);
    chk("R6 trailer", trailerOut, (found && v.trail) ? v.word : 32'h0);
    chk("R2 preamble count", 32'(preCount), 32'(int'(v.busyN) + 1));
    chk("R7 exchanges after frame", 32'(afterFrame), 32'(expAfter));
    for (int b = 0; b < 6; b++) chk("R1 frame byte", 32'(frm[b]), 32'(expFrame[47 - 8*b -: 8]));
    xAtDone = totalX;
    @(negedge clk);
    chk("R8 done single cycle", 32'(done), 0);
    repeat (20) @(negedge clk);
    chk("R7 no exchange after done", 32'(totalX), 32'(xAtDone));
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        failures++; checks++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    bit seen;
    vec_t v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
    chk("R10 timeout", 32'(timeout), 0);
    chk("R10 go", 32'(xferGo), 0);
    chk("R10 r1", 32'(r1Out), 32'hFF);
    chk("R10 trailer", trailerOut, 0);

    for (int i = 0; i < NV; i++) begin
      launch(VEC[i]);
      waitDone(seen);
      checkTxn(VEC[i], seen);
    end

    // R9: start while busy is ignored
    v = VEC[5];
    launch(v);
    repeat (10) @(negedge clk);
    cmdIdx = 6'd9; startI = 1'b1;
    @(negedge clk);
    startI = 1'b0;
    waitDone(seen);
    checkTxn(v, seen);
    chk("R9 frame head unchanged", 32'(frm[0]), 32'h41);

    // R3: card never ready
    v = '{6'd0, 32'h0, 8'h95, 1'b1, 16'd300, 8'd0, 8'h01, 32'hDEAD_BEEF};
    launch(v);
    waitDone(seen);
    chk("R3 done seen", 32'(seen), 1);
    chk("R3 timeout", 32'(timeout), 1);
    chk("R3 r1", 32'(r1Out), 32'hFF);
    chk("R3 no frame sent", 32'(frmN), 0);
    chk("R3 preamble bound", 32'(preCount), 255);
    chk("R3 trailer zero", trailerOut, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule